// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block chooses which interrupt source a simple sequential CPU services next. Each source has a request flag, an enable bit and a one-bit priority (0 low, 1 high). A global enable gates every source. Each cycle the controller captures the qualified flags. In the cycle after that it polls the captured set. High-priority requests come first. Within a level the lowest source index wins. When vectoring is allowed, the controller raises a one-cycle acknowledge strobe to the CPU together with the winning index.

Two in-service bits record which priority levels have a handler running. A high request can preempt a low handler. Nothing preempts a high handler, and a request is never taken while a handler of equal level runs. The CPU tells the block three things: when it is in the final cycle of an instruction, when that instruction is a return-from-interrupt, and when it touches the enable or priority settings. A vector is only issued on a final cycle that is neither of those two instruction kinds. Sources `0..N_EXT-1` are active-low external pins, and each can run in edge mode or level mode. The rest are internal flags that software clears.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset `vec_req_o` is 0, `insvc_o` is 2'b00 and every bit of `flags_o` is 0 while the external pins are high.
- R2: While only the low in-service bit (`insvc_o[0]`) is set, an enabled high-priority request is still vectored, and the acknowledge sets `insvc_o[1]`.
- R3: While `insvc_o[1]` is set, no vector is issued.
- R4: If high and low requests are pending together, the high one is vectored first. Among requests of equal priority, the lowest source index is vectored first.
- R5: If a flag becomes set at clock edge k and vectoring is allowed, `vec_req_o` is 1 for the single cycle following edge k+2, with `vec_idx_o` holding the source index.
- R6: No vector is issued in a cycle where `last_cyc_i` is 0.
- R7: No vector is issued in a cycle where `reti_i` or `reg_acc_i` is 1. A request pending at that point is vectored on the next allowed final cycle.
- R8: A source whose `en_i` bit is 0 is never vectored. When `glob_en_i` is 0, no source is vectored.
- R9: An external source in edge mode (`edge_mode_i` bit = 1) sets its flag on a 1-to-0 pin transition. Vectoring that source clears the flag. A pin that stays low does not set the flag again.
- R10: An external source in level mode (`edge_mode_i` bit = 0) has a flag equal to the inverted pin, registered one cycle. Vectoring does not clear it, and `sw_clr_i` has no effect on it.
- R11: An acknowledge sets the in-service bit of the winner's level (bit 1 for high, bit 0 for low). `reti_i` clears the highest in-service bit that is set.
- R12: An internal flag is set by `hw_set_i` or `sw_set_i` and cleared only by `sw_clr_i`. Vectoring leaves it set, and a set wins over a simultaneous clear.
- R13: While `insvc_o[0]` is set, a pending low-priority request is not vectored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_n_i | input | N_EXT | Active-low external request pins (sources 0..N_EXT-1) |
| edge_mode_i | input | N_EXT | Per external pin: 1 edge mode, 0 level mode |
| hw_set_i | input | N_SRC-N_EXT | Hardware set pulses for internal sources N_EXT.. |
| sw_set_i | input | N_SRC | Software set of request flags |
| sw_clr_i | input | N_SRC | Software clear of request flags |
| en_i | input | N_SRC | Per-source enable |
| prio_i | input | N_SRC | Per-source priority, 1 = high |
| glob_en_i | input | 1 | Global enable |
| last_cyc_i | input | 1 | CPU is in the final cycle of an instruction |
| reti_i | input | 1 | Current instruction is a return-from-interrupt (valid with last_cyc_i) |
| reg_acc_i | input | 1 | Current instruction accesses enable/priority settings |
| vec_req_o | output | 1 | One-cycle acknowledge/vector strobe |
| vec_idx_o | output | $clog2(N_SRC) | Winning source index |
| insvc_o | output | 2 | In-service bits: [1] high level, [0] low level |
| flags_o | output | N_SRC | Current request flags |

## Verification
A corrupted in-service bit shows up at the ports on the first acknowledge it should have allowed or blocked. A stuck high bit silences every later vector. A lost low bit lets a second low request through one cycle after the first acknowledge. Wrong polling order or a wrong priority compare appears as a mismatched `vec_idx_o` on the very next strobe. A flag-clearing fault shows on `flags_o` one cycle after the acknowledge: an edge flag that survives, or a level or internal flag that vanishes. An off-by-one in the sampling stage moves the strobe by one cycle relative to the exact edge-count check.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int LVL_LO = 0;
    localparam int LVL_HI = 1;
    typedef logic [1:0] lvl_vec_t;
endpackage

// File: rtl/irqc_flags.sv
module irqc_flags #(
    parameter int N_SRC = 8,
    parameter int N_EXT = 2,
    localparam int IDX_W = $clog2(N_SRC),
    localparam int N_INT = N_SRC - N_EXT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] ext_n_i,
    input  logic [N_EXT-1:0] edge_mode_i,
    input  logic [N_INT-1:0] hw_set_i,
    input  logic [N_SRC-1:0] sw_set_i,
    input  logic [N_SRC-1:0] sw_clr_i,
    input  logic             ack_i,
    input  logic [IDX_W-1:0] ack_idx_i,
    output logic [N_SRC-1:0] flag_o
);
    typedef struct packed {
        logic [N_SRC-1:0] flag;
        logic [N_EXT-1:0] pin_prev;
    } fl_st_t;

    fl_st_t st_d, st_q;
    logic [N_SRC-1:0] flag_nxt;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        if (g < N_EXT) begin : g_ext
            logic fall, acked;
            assign fall  = st_q.pin_prev[g] & ~ext_n_i[g];
            assign acked = ack_i && (ack_idx_i == IDX_W'(g));
            assign flag_nxt[g] = edge_mode_i[g]
                ? ((st_q.flag[g] & ~sw_clr_i[g] & ~acked) | sw_set_i[g] | fall)
                : ~ext_n_i[g];
        end else begin : g_int
            assign flag_nxt[g] = (st_q.flag[g] & ~sw_clr_i[g])
                               | hw_set_i[g-N_EXT] | sw_set_i[g];
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.flag     = flag_nxt;
        st_d.pin_prev = ext_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag     <= '0;
            st_q.pin_prev <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/irqc_poll.sv
module irqc_poll #(
    parameter int N_SRC = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] flag_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic [N_SRC-1:0] prio_i,
    input  logic             glob_en_i,
    output logic             hi_any_o,
    output logic [IDX_W-1:0] hi_idx_o,
    output logic             lo_any_o,
    output logic [IDX_W-1:0] lo_idx_o
);
    typedef struct packed {
        logic [N_SRC-1:0] hi;
        logic [N_SRC-1:0] lo;
    } smp_st_t;

    smp_st_t st_d, st_q;
    logic [N_SRC-1:0] elig;

    always_comb begin
        elig    = flag_i & en_i & {N_SRC{glob_en_i}};
        st_d.hi = elig & prio_i;
        st_d.lo = elig & ~prio_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // fixed polling order: lowest index first within a level
    always_comb begin
        hi_idx_o = '0;
        lo_idx_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (st_q.hi[i]) hi_idx_o = IDX_W'(i);
            if (st_q.lo[i]) lo_idx_o = IDX_W'(i);
        end
        hi_any_o = |st_q.hi;
        lo_any_o = |st_q.lo;
    end
endmodule

// File: rtl/irqc_nest.sv
module irqc_nest
    import irqc_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_any_i,
    input  logic [IDX_W-1:0] hi_idx_i,
    input  logic             lo_any_i,
    input  logic [IDX_W-1:0] lo_idx_i,
    input  logic             last_cyc_i,
    input  logic             reti_i,
    input  logic             reg_acc_i,
    output logic             fire_o,
    output logic [IDX_W-1:0] fire_idx_o,
    output logic             vec_req_o,
    output logic [IDX_W-1:0] vec_idx_o,
    output lvl_vec_t         insvc_o
);
    typedef struct packed {
        lvl_vec_t         isv;
        logic             vec;
        logic [IDX_W-1:0] idx;
    } nst_st_t;

    nst_st_t st_d, st_q;
    logic gate, take_hi, take_lo;

    always_comb begin
        gate    = last_cyc_i & ~reti_i & ~reg_acc_i;
        take_hi = gate & hi_any_i & ~st_q.isv[LVL_HI];
        take_lo = gate & ~take_hi & lo_any_i & (st_q.isv == 2'b00);
        fire_o     = take_hi | take_lo;
        fire_idx_o = take_hi ? hi_idx_i : lo_idx_i;

        st_d     = st_q;
        st_d.vec = fire_o;
        if (fire_o) st_d.idx = fire_idx_o;
        if (reti_i) begin
            if (st_q.isv[LVL_HI]) st_d.isv[LVL_HI] = 1'b0;
            else                  st_d.isv[LVL_LO] = 1'b0;
        end
        if (take_hi) st_d.isv[LVL_HI] = 1'b1;
        if (take_lo) st_d.isv[LVL_LO] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_req_o = st_q.vec;
    assign vec_idx_o = st_q.idx;
    assign insvc_o   = st_q.isv;
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl #(
    parameter int N_SRC = 8,
    parameter int N_EXT = 2,
    localparam int IDX_W = $clog2(N_SRC),
    localparam int N_INT = N_SRC - N_EXT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] ext_n_i,
    input  logic [N_EXT-1:0] edge_mode_i,
    input  logic [N_INT-1:0] hw_set_i,
    input  logic [N_SRC-1:0] sw_set_i,
    input  logic [N_SRC-1:0] sw_clr_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic [N_SRC-1:0] prio_i,
    input  logic             glob_en_i,
    input  logic             last_cyc_i,
    input  logic             reti_i,
    input  logic             reg_acc_i,
    output logic             vec_req_o,
    output logic [IDX_W-1:0] vec_idx_o,
    output logic [1:0]       insvc_o,
    output logic [N_SRC-1:0] flags_o
);
    logic             hi_any, lo_any, fire;
    logic [IDX_W-1:0] hi_idx, lo_idx, fire_idx;

    irqc_flags #(.N_SRC(N_SRC), .N_EXT(N_EXT)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .ext_n_i(ext_n_i), .edge_mode_i(edge_mode_i),
        .hw_set_i(hw_set_i), .sw_set_i(sw_set_i), .sw_clr_i(sw_clr_i),
        .ack_i(fire), .ack_idx_i(fire_idx),
        .flag_o(flags_o)
    );

    irqc_poll #(.N_SRC(N_SRC)) u_poll (
        .clk(clk), .rst_n(rst_n),
        .flag_i(flags_o), .en_i(en_i), .prio_i(prio_i), .glob_en_i(glob_en_i),
        .hi_any_o(hi_any), .hi_idx_o(hi_idx),
        .lo_any_o(lo_any), .lo_idx_o(lo_idx)
    );

    irqc_nest #(.N_SRC(N_SRC)) u_nest (
        .clk(clk), .rst_n(rst_n),
        .hi_any_i(hi_any), .hi_idx_i(hi_idx),
        .lo_any_i(lo_any), .lo_idx_i(lo_idx),
        .last_cyc_i(last_cyc_i), .reti_i(reti_i), .reg_acc_i(reg_acc_i),
        .fire_o(fire), .fire_idx_o(fire_idx),
        .vec_req_o(vec_req_o), .vec_idx_o(vec_idx_o), .insvc_o(insvc_o)
    );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       vec_req_o,
    input logic [1:0] insvc_o,
    input logic       last_cyc_i,
    input logic       reti_i,
    input logic       reg_acc_i,
    input logic       glob_en_i
);
    AST_HI_NOT_PREEMPTED: assert property (@(posedge clk) disable iff (!rst_n)
        insvc_o[1] |=> !vec_req_o); // R3

    AST_ONLY_LAST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !last_cyc_i |=> !vec_req_o); // R6

    AST_BLOCK_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i || reg_acc_i) |=> !vec_req_o); // R7

    AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en_i |-> ##2 !vec_req_o); // R8

    AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req_o |-> (insvc_o != 2'b00)); // R11

    AST_RETURN_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && insvc_o != 2'b00)
        |=> ($countones(insvc_o) == $countones($past(insvc_o)) - 1)); // R11
endmodule

bind nested_irq_ctrl irqc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .vec_req_o(vec_req_o), .insvc_o(insvc_o),
    .last_cyc_i(last_cyc_i), .reti_i(reti_i), .reg_acc_i(reg_acc_i),
    .glob_en_i(glob_en_i)
);

// File: tb/tb_nested_irq_ctrl.sv
module tb_nested_irq_ctrl;
    localparam int N_SRC = 8;
    localparam int N_EXT = 2;
    localparam int IDX_W = $clog2(N_SRC);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_EXT-1:0] ext_n = '1;
    logic [N_EXT-1:0] edge_mode = 2'b01;
    logic [N_SRC-N_EXT-1:0] hw_set = '0;
    logic [N_SRC-1:0] sw_set = '0, sw_clr = '0, en = '1, prio = '0;
    logic glob_en = 1'b1, last_cyc = 1'b1, reti = 1'b0, reg_acc = 1'b0;
    logic vec_req_o;
    logic [IDX_W-1:0] vec_idx_o;
    logic [1:0] insvc_o;
    logic [N_SRC-1:0] flags_o;

    int total = 0, failed = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    nested_irq_ctrl #(.N_SRC(N_SRC), .N_EXT(N_EXT)) dut (
        .clk(clk), .rst_n(rst_n), .ext_n_i(ext_n), .edge_mode_i(edge_mode),
        .hw_set_i(hw_set), .sw_set_i(sw_set), .sw_clr_i(sw_clr), .en_i(en),
        .prio_i(prio), .glob_en_i(glob_en), .last_cyc_i(last_cyc),
        .reti_i(reti), .reg_acc_i(reg_acc), .vec_req_o(vec_req_o),
        .vec_idx_o(vec_idx_o), .insvc_o(insvc_o), .flags_o(flags_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: every strobe must match the head of the expected queue
    always @(negedge clk) begin
        if (rst_n && vec_req_o) begin
            if (exp_q.size() == 0) chk(1'b0, "R3/R13 unexpected vector", int'(vec_idx_o), -1);
            else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(vec_idx_o) == e, "R4 vector index", int'(vec_idx_o), e);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_hw(input int i);
        hw_set[i-N_EXT] = 1'b1; cyc(1); hw_set = '0;
    endtask

    task automatic pulse_clr(input int i);
        sw_clr[i] = 1'b1; cyc(1); sw_clr = '0;
    endtask

    task automatic do_reti();
        reti = 1'b1; cyc(1); reti = 1'b0;
    endtask

    task automatic settle(input string req);
        cyc(6);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        #(200000 * 20);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk(vec_req_o == 1'b0, "R1 vec_req", vec_req_o, 0);
        chk(insvc_o == 2'b00, "R1 insvc", insvc_o, 0);
        chk(flags_o == '0, "R1 flags", int'(flags_o), 0);

        // R5 exact latency, R12 flag kept after vectoring
        exp_q.push_back(5);
        hw_set[5-N_EXT] = 1'b1; cyc(1); hw_set = '0;
        chk(flags_o[5] == 1'b1, "R12 hw set", flags_o[5], 1);
        cyc(1);
        chk(vec_req_o == 1'b0, "R5 early", vec_req_o, 0);
        cyc(1);
        chk(vec_req_o == 1'b1, "R5 strobe", vec_req_o, 1);
        chk(insvc_o == 2'b01, "R11 low level set", insvc_o, 1);
        cyc(1);
        chk(vec_req_o == 1'b0, "R5 single cycle", vec_req_o, 0);
        chk(flags_o[5] == 1'b1, "R12 not cleared by vector", flags_o[5], 1);
        sw_clr[5] = 1'b1; sw_set[5] = 1'b1; cyc(1); sw_clr = '0; sw_set = '0;
        chk(flags_o[5] == 1'b1, "R12 set wins", flags_o[5], 1);
        pulse_clr(5);
        chk(flags_o[5] == 1'b0, "R12 sw clear", flags_o[5], 0);
        cyc(3); do_reti();
        chk(insvc_o == 2'b00, "R11 reti", insvc_o, 0);

        // R4 high over low, then R3 hold while high in service
        prio[6] = 1'b1;
        exp_q.push_back(6);
        hw_set[3-N_EXT] = 1'b1; hw_set[6-N_EXT] = 1'b1; cyc(1); hw_set = '0;
        settle("R4 high first");
        chk(insvc_o == 2'b10, "R11 high level set", insvc_o, 2);
        cyc(5);                        // R3: low 3 stays pending, monitor sees nothing
        pulse_clr(6); cyc(2);
        exp_q.push_back(3);
        do_reti();
        settle("R3 low after high returns");
        chk(insvc_o == 2'b01, "R11 low after high", insvc_o, 1);
        pulse_clr(3); cyc(2); do_reti();
        prio[6] = 1'b0;

        // R4 equal priority order, R13 equal level blocked
        exp_q.push_back(2);
        hw_set[2-N_EXT] = 1'b1; hw_set[4-N_EXT] = 1'b1; cyc(1); hw_set = '0;
        settle("R4 lowest index");
        cyc(4);                        // R13: 4 held off by low in-service
        pulse_clr(2); cyc(2);
        exp_q.push_back(4);
        do_reti();
        settle("R13 after return");
        pulse_clr(4); cyc(2); do_reti();

        // R2 nesting
        prio[7] = 1'b1;
        exp_q.push_back(3);
        pulse_hw(3);
        settle("R2 low entry");
        exp_q.push_back(7);
        pulse_hw(7);
        settle("R2 preempt");
        chk(insvc_o == 2'b11, "R2 both levels", insvc_o, 3);
        pulse_clr(7); cyc(2); do_reti();
        chk(insvc_o == 2'b01, "R11 highest cleared first", insvc_o, 1);
        pulse_clr(3); cyc(2); do_reti();
        chk(insvc_o == 2'b00, "R11 all clear", insvc_o, 0);
        prio[7] = 1'b0;

        // R6 only on final cycle
        last_cyc = 1'b0;
        pulse_hw(5);
        cyc(6);
        chk(vec_req_o == 1'b0, "R6 no vector mid-instruction", vec_req_o, 0);
        exp_q.push_back(5);
        last_cyc = 1'b1;
        settle("R6 resumes");
        pulse_clr(5); cyc(2); do_reti();

        // R7 register access blocks, next final cycle allowed
        reg_acc = 1'b1;
        pulse_hw(5);
        cyc(5);
        exp_q.push_back(5);
        reg_acc = 1'b0;
        cyc(1);
        chk(vec_req_o == 1'b1, "R7 next instruction", vec_req_o, 1);
        settle("R7 drain");
        pulse_clr(5); cyc(2); do_reti();

        // R8 masking
        en[5] = 1'b0;
        pulse_hw(5);
        cyc(5);
        en[5] = 1'b1; glob_en = 1'b0;
        cyc(5);
        chk(flags_o[5] == 1'b1, "R8 flag pending while masked", flags_o[5], 1);
        exp_q.push_back(5);
        glob_en = 1'b1;
        settle("R8 unmasked");
        pulse_clr(5); cyc(2); do_reti();

        // R9 edge mode on source 0
        exp_q.push_back(0);
        ext_n[0] = 1'b0;
        settle("R9 edge vector");
        chk(flags_o[0] == 1'b0, "R9 cleared by vector", flags_o[0], 0);
        cyc(3);
        chk(flags_o[0] == 1'b0, "R9 no re-set while low", flags_o[0], 0);
        ext_n[0] = 1'b1; cyc(1); do_reti();

        // R10 level mode on source 1
        exp_q.push_back(1);
        ext_n[1] = 1'b0;
        settle("R10 level vector");
        chk(flags_o[1] == 1'b1, "R10 kept after vector", flags_o[1], 1);
        pulse_clr(1);
        chk(flags_o[1] == 1'b1, "R10 sw clear ignored", flags_o[1], 1);
        ext_n[1] = 1'b1; cyc(1);
        chk(flags_o[1] == 1'b0, "R10 follows pin", flags_o[1], 0);
        do_reti();
        settle("R10 idle");
        chk(insvc_o == 2'b00, "R11 final", insvc_o, 0);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule